// File: doc/BRIEF.md
# Seconds-Minutes-Hours Real-Time Clock Counter

This block keeps time of day from a slow tick. A tick-enable input, expected once per 32.768 kHz period, advances a free-running prescaler counter (16 bits by default). The counter's top bit is always held at one, so it wraps once every half of its full range: 32768 ticks, or exactly one second. At each wrap only that top bit is set again. The lower bits are never loaded by the reload, so no error builds up over time.

Each wrap produces a single-cycle seconds pulse and advances a chain of three modulo counters. Seconds count 0 to 59, minutes count 0 to 59, and hours count 0 to 23. Each counter steps when the one below it wraps. A synchronous load strobe sets all three fields and restarts the one-second period. A field value at or above its modulus is stored as zero. The tick input may be driven every system clock cycle, which lets a bench run many simulated seconds in a short time.

Top module: `rtc_hms`

## Requirements
- R1: After reset, seconds, minutes and hours read 0, the seconds pulse is low, and the first pulse follows exactly 2^(CNT_W-1) ticks.
- R2: A cycle with tick_en low does not advance the prescaler, so idle cycles only delay the next pulse and do not change the number of ticks it needs.
- R3: sec_pulse_o is high for exactly one cycle: the cycle after the edge where a tick is taken while the prescaler holds all ones. It is low at every other time.
- R4: The reload at a wrap sets only the prescaler's top bit and leaves the lower bits as the increment left them, so consecutive pulses are exactly 2^(CNT_W-1) ticks apart and the top bit reads one at all times.
- R5: Each pulse advances seconds by one, and seconds wrap from 59 to 0.
- R6: Minutes advance by one when seconds wrap from 59, and minutes wrap from 59 to 0; they do not change at any other time except on a load.
- R7: Hours advance by one when minutes wrap from 59, and hours wrap from 23 to 0.
- R8: load_en writes the three load fields into the time registers and sets the prescaler to 2^(CNT_W-1). It produces no pulse and takes priority over a tick in the same cycle.
- R9: A load field at or above its modulus (60 for seconds and minutes, 24 for hours) is stored as 0, and each field is clamped on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle tick from the 32.768 kHz time base |
| load_en | input | 1 | Load strobe for the time fields |
| load_sec | input | 6 | Seconds value to load |
| load_min | input | 6 | Minutes value to load |
| load_hr | input | 5 | Hours value to load |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| hr_o | output | 5 | Hours, 0 to 23 |
| sec_pulse_o | output | 1 | One-cycle pulse per second |

## Verification
The bench uses a narrow prescaler and tries the tick input in three patterns. The first is a solid run of ticks, which gives the exact pulse cycle. The second has ticks spaced by idle cycles, which separates counting ticks from counting clocks. The third loads values just below a rollover, which exercises the seconds, minutes and hours wraps together. Loads are also given a tick in the same cycle while the prescaler is all ones, which shows whether the load wins over a pending wrap. Loads of out-of-range values show whether each field is clamped on its own.

// File: rtl/rtc_hms_pkg.sv
package rtc_hms_pkg;
   localparam int DEF_CNT_W   = 16;
   localparam int DEF_SEC_MOD = 60;
   localparam int DEF_MIN_MOD = 60;
   localparam int DEF_HR_MOD  = 24;

   function automatic int fld_width(input int modulus);
      return (modulus < 2) ? 1 : $clog2(modulus);
   endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
   parameter int CNT_W = rtc_hms_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_en,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] TOP_BIT = {1'b1, {(CNT_W-1){1'b0}}};

   if (CNT_W < 2) begin : g_bad_width
      $error("rtc_prescale: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   // The increment wraps to zero at all ones; OR-ing in the top bit touches only bit CNT_W-1.
   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= TOP_BIT;
      else if (load_en) cnt_q <= TOP_BIT;
      else if (tick_en) cnt_q <= (cnt_q + 1'b1) | TOP_BIT;
   end

   assign cnt_o = cnt_q;
   assign ovf_o = tick_en & ~load_en & (&cnt_q);
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
   parameter int MOD = 60,
   parameter int W   = rtc_hms_pkg::fld_width(MOD)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] val_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] LAST = W'(MOD - 1);

   if (MOD < 2 || MOD > (1 << W)) begin : g_bad_mod
      $error("rtc_field: MOD must lie in 2 .. 2**W");
   end

   logic [W-1:0] val_q;
   logic [W-1:0] nxt;
   logic [W-1:0] load_fix;

   if (MOD == (1 << W)) begin : g_pow2
      assign nxt      = val_q + 1'b1;
      assign load_fix = load_val;
   end else begin : g_cmp
      assign nxt      = (val_q == LAST) ? '0 : val_q + 1'b1;
      assign load_fix = (load_val > LAST) ? '0 : load_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       val_q <= '0;
      else if (load_en) val_q <= load_fix;
      else if (inc_i)   val_q <= nxt;
   end

   assign val_o  = val_q;
   assign wrap_o = inc_i & ~load_en & (val_q == LAST);
endmodule

// File: rtl/rtc_hms.sv
module rtc_hms #(
   parameter int CNT_W   = rtc_hms_pkg::DEF_CNT_W,
   parameter int SEC_MOD = rtc_hms_pkg::DEF_SEC_MOD,
   parameter int MIN_MOD = rtc_hms_pkg::DEF_MIN_MOD,
   parameter int HR_MOD  = rtc_hms_pkg::DEF_HR_MOD,
   localparam int SEC_W  = rtc_hms_pkg::fld_width(SEC_MOD),
   localparam int MIN_W  = rtc_hms_pkg::fld_width(MIN_MOD),
   localparam int HR_W   = rtc_hms_pkg::fld_width(HR_MOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_en,
   input  logic [SEC_W-1:0] load_sec,
   input  logic [MIN_W-1:0] load_min,
   input  logic [HR_W-1:0]  load_hr,
   output logic [SEC_W-1:0] sec_o,
   output logic [MIN_W-1:0] min_o,
   output logic [HR_W-1:0]  hr_o,
   output logic             sec_pulse_o
);
   logic [CNT_W-1:0] pre_cnt;
   logic             pre_ovf;
   logic             sec_wrap;
   logic             min_wrap;
   logic             hr_wrap;
   logic             pulse_q;

   rtc_prescale #(.CNT_W(CNT_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .load_en (load_en),
      .cnt_o   (pre_cnt),
      .ovf_o   (pre_ovf)
   );

   rtc_field #(.MOD(SEC_MOD), .W(SEC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc_i(pre_ovf), .load_en(load_en),
      .load_val(load_sec), .val_o(sec_o), .wrap_o(sec_wrap)
   );

   rtc_field #(.MOD(MIN_MOD), .W(MIN_W)) u_min (
      .clk(clk), .rst_n(rst_n), .inc_i(sec_wrap), .load_en(load_en),
      .load_val(load_min), .val_o(min_o), .wrap_o(min_wrap)
   );

   rtc_field #(.MOD(HR_MOD), .W(HR_W)) u_hr (
      .clk(clk), .rst_n(rst_n), .inc_i(min_wrap), .load_en(load_en),
      .load_val(load_hr), .val_o(hr_o), .wrap_o(hr_wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= pre_ovf;
   end

   assign sec_pulse_o = pulse_q;

   logic unused_ok;
   assign unused_ok = hr_wrap;
endmodule

// File: rtl/rtc_hms_chk.sv
module rtc_hms_chk #(
   parameter int CNT_W   = 16,
   parameter int SEC_MOD = 60,
   parameter int MIN_MOD = 60,
   parameter int HR_MOD  = 24,
   parameter int SEC_W   = 6,
   parameter int MIN_W   = 6,
   parameter int HR_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             load_en,
   input logic [CNT_W-1:0] cnt,
   input logic [SEC_W-1:0] sec_o,
   input logic [MIN_W-1:0] min_o,
   input logic [HR_W-1:0]  hr_o,
   input logic             sec_pulse_o
);
   localparam logic [CNT_W-1:0] TOP_BIT = {1'b1, {(CNT_W-1){1'b0}}};

   AST_PULSE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load_en && (&cnt)) |=> sec_pulse_o);                        // R3
   AST_PULSE_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_en && !load_en && (&cnt)) |=> !sec_pulse_o);                      // R3
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse_o |=> !sec_pulse_o);                                           // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load_en) |=> $stable(cnt));                                // R2
   AST_TOP_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[CNT_W-1]);                                                           // R4
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (cnt == TOP_BIT) && !sec_pulse_o);                           // R8
   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse_o |-> (sec_o == (($past(sec_o) == SEC_W'(SEC_MOD-1)) ? '0
                                 : SEC_W'($past(sec_o) + 1'b1))));             // R5
   AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_o < SEC_W'(SEC_MOD));                                                // R5
   AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_pulse_o && !$past(load_en)) |-> $stable(min_o));                   // R6
   AST_MIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      min_o < MIN_W'(MIN_MOD));                                                // R6
   AST_HR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hr_o < HR_W'(HR_MOD));                                                   // R7
endmodule

bind rtc_hms rtc_hms_chk #(
   .CNT_W(CNT_W), .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD),
   .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
   .cnt(pre_cnt), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o),
   .sec_pulse_o(sec_pulse_o)
);

// File: tb/rtc_hms_tb_top.sv
module rtc_hms_tb_top;
   localparam int CW   = 6;
   localparam int HALF = 1 << (CW - 1);
   localparam int FULL = 1 << CW;

   typedef struct {
      int cyc;
      int s;
      int m;
      int h;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       load_en = 1'b0;
   logic [5:0] load_sec = '0;
   logic [5:0] load_min = '0;
   logic [4:0] load_hr = '0;
   logic [5:0] sec_o;
   logic [5:0] min_o;
   logic [4:0] hr_o;
   logic       sec_pulse_o;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   int   mcnt, ms, mm, mh;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_hms #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
      .load_sec(load_sec), .load_min(load_min), .load_hr(load_hr),
      .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .sec_pulse_o(sec_pulse_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void model_second();
      ms++;
      if (ms == 60) begin
         ms = 0;
         mm++;
         if (mm == 60) begin
            mm = 0;
            mh = (mh == 23) ? 0 : mh + 1;
         end
      end
   endfunction

   // Driver: one cycle, with or without a tick; predicts pulses into the scoreboard.
   task automatic drive(input bit en);
      @(negedge clk);
      load_en = 1'b0;
      tick_en = en;
      if (en) begin
         if (mcnt == FULL - 1) begin
            mcnt = HALF;
            model_second();
            sb_q.push_back('{cyc + 1, ms, mm, mh});
         end else begin
            mcnt++;
         end
      end
   endtask

   task automatic run(input int ticks, input int gap);
      for (int i = 0; i < ticks; i++) begin
         drive(1'b1);
         for (int g = 0; g < gap; g++) drive(1'b0);
      end
      drive(1'b0);
   endtask

   task automatic do_load(input int s, input int m, input int h, input bit with_tick,
                          input string req);
      @(negedge clk);
      load_en  = 1'b1;
      tick_en  = with_tick;
      load_sec = 6'(s);
      load_min = 6'(m);
      load_hr  = 5'(h);
      mcnt = HALF;
      ms = (s >= 60) ? 0 : s;
      mm = (m >= 60) ? 0 : m;
      mh = (h >= 24) ? 0 : h;
      @(negedge clk);
      load_en = 1'b0;
      tick_en = 1'b0;
      check({req, " sec"}, int'(sec_o), ms);
      check({req, " min"}, int'(min_o), mm);
      check({req, " hr"}, int'(hr_o), mh);
      check({req, " no pulse"}, int'(sec_pulse_o), 0);
   endtask

   // Monitor: pops predicted pulses and compares cycle and time fields.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
            exp_t miss;
            miss = sb_q.pop_front();
            check("R3 missing pulse cycle", cyc, miss.cyc);
         end
         if (sec_pulse_o) begin
            if (sb_q.size() == 0) begin
               check("R3 unexpected pulse", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check("R4 pulse cycle", cyc, e.cyc);
               check("R5 seconds", int'(sec_o), e.s);
               check("R6 minutes", int'(min_o), e.m);
               check("R7 hours", int'(hr_o), e.h);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check("watchdog expired", 1, 0);
         finish_run();
      end
   end

   initial begin
      mcnt = HALF; ms = 0; mm = 0; mh = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset sec", int'(sec_o), 0);
      check("R1 reset min", int'(min_o), 0);
      check("R1 reset hr", int'(hr_o), 0);
      check("R1 reset pulse", int'(sec_pulse_o), 0);

      // R1 R3 R5: solid ticks from reset, first pulse after HALF ticks
      run(3 * HALF + 5, 0);
      // R2 R4: ticks separated by idle cycles
      run(2 * HALF + 3, 2);
      run(HALF + 7, 1);

      // R5 R6 R7 R8: load just before midnight and roll over
      do_load(57, 59, 23, 1'b0, "R8 load near midnight");
      run(4 * HALF + 2, 0);
      do_load(58, 59, 10, 1'b0, "R8 load minute edge");
      run(3 * HALF, 1);

      // R8: load in the same cycle as a wrapping tick
      while (mcnt != FULL - 1) drive(1'b1);
      do_load(12, 34, 5, 1'b1, "R8 load beats tick");
      run(HALF + 1, 0);

      // R9: out-of-range values, each field clamped on its own
      do_load(60, 60, 24, 1'b0, "R9 clamp at modulus");
      do_load(63, 7, 31, 1'b0, "R9 clamp seconds and hours");
      do_load(9, 63, 3, 1'b0, "R9 clamp minutes");
      do_load(59, 59, 23, 1'b0, "R9 top legal values");
      run(HALF + 2, 0);

      repeat (3) drive(1'b0);
      check("R3 scoreboard drained", sb_q.size(), 0);
      finish_run();
   end
endmodule